// File: doc/BRIEF.md
# MESI Line State Controller

This block holds the coherence state of one line in a write-back cache that uses a four-state invalidation protocol. The four states are Modified, Exclusive, Shared and Invalid. Modified is private and dirty. Exclusive is private and matches memory. Shared may also be held by other caches and matches memory. Invalid holds nothing.

Each cycle the block may receive one of several events:
- a processor read, write or eviction of the line;
- a snooped read miss or write miss from another cache that matches this line;
- a shared-line input that reports whether another cache answered a read miss.

From the current state and the winning event it decides the next state. It also decides which bus command to issue, whether the line must be written back, and whether it must supply the data so that memory does not answer.

A processor write to an Exclusive line upgrades to Modified without any bus traffic. A write to a Shared line must invalidate the other copies first. The block does not cover data storage, tag compare, arbitration or bus timing.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After synchronous reset, state_o is Invalid, cmd_o is none and wb_o and supply_o are 0. The state codes are I=0, S=1, E=2, M=3. The command codes are none=0, read miss=1, write miss=2, invalidate=3.
- R2: A processor read in Invalid issues a read miss (1). The line moves to E when shared_i is 0 and to S when shared_i is 1.
- R3: A processor write in Invalid issues a write miss (2) and moves the line to M.
- R4: A processor write in S issues an invalidate (3) and moves the line to M.
- R5: A processor write in E moves the line to M with command none and no write back.
- R6: Read hits in M, E and S, and write hits in M, leave the state unchanged and issue no command, no write back and no supply. Processor reads and writes in a state they do not name behave as R2 to R5 state.
- R7: A snooped read miss moves M to S with wb_o=1 and supply_o=1, and moves E to S silently. It leaves S and I unchanged.
- R8: A snooped write miss moves M to I with wb_o=1 and supply_o=1, and moves E and S to I silently. It leaves I unchanged.
- R9: Eviction moves M to I with wb_o=1 and supply_o=0, and moves E and S to I silently. It issues no bus command.
- R10: Snooped events take priority over processor events, and any processor event in that cycle is ignored. A snooped write miss takes priority over a snooped read miss. Among processor events, eviction wins over write, and write wins over read.
- R11: All outputs are registered. The response to an event appears after the clock edge that samples it. A cycle with no event gives command none, wb_o=0 and supply_o=0, and keeps the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_rd_i | input | 1 | Processor read of the line |
| cpu_wr_i | input | 1 | Processor write of the line |
| evict_i | input | 1 | Processor eviction of the line |
| snp_rd_i | input | 1 | Snooped read miss for this line |
| snp_wr_i | input | 1 | Snooped write miss for this line |
| shared_i | input | 1 | Another cache holds the line (valid with a read miss) |
| state_o | output | 2 | Current line state |
| cmd_o | output | 2 | Bus command to issue |
| wb_o | output | 1 | Write back the line |
| supply_o | output | 1 | Supply data and abort the memory response |

## Verification
On every cycle the assertions check the following:
- the silent upgrade from E to M;
- the invalidate issued on a write to S;
- that a snooped write miss always reaches Invalid;
- that a write back never appears unless the line was Modified;
- that supply never appears without a write back.

Only the bench's scenarios can show the full transition table. This includes:
- the fill into E or S chosen by shared_i;
- the priority among colliding events;
- that a processor request is dropped when a snoop arrives in the same cycle.

The bench covers these by comparing every cycle against a reference model, over directed sequences and seeded random traffic.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  localparam int ST_W  = 2;
  localparam int CMD_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3
  } line_st_t;

  typedef enum logic [CMD_W-1:0] {
    CMD_NONE = 2'd0, CMD_RDMISS = 2'd1, CMD_WRMISS = 2'd2, CMD_INV = 2'd3
  } bus_cmd_t;

  typedef enum logic [2:0] {
    EV_NONE, EV_SNP_WR, EV_SNP_RD, EV_EVICT, EV_WR, EV_RD
  } line_ev_t;

  typedef struct packed {
    line_st_t nxt;
    bus_cmd_t cmd;
    logic     wb;
    logic     sup;
  } line_act_t;
endpackage

// File: rtl/mesi_evt_arb.sv
module mesi_evt_arb
  import mesi_pkg::*;
(
  input  logic     cpu_rd,
  input  logic     cpu_wr,
  input  logic     evict,
  input  logic     snp_rd,
  input  logic     snp_wr,
  output line_ev_t ev
);
  // Snoops first: the bus has already been won by another cache.
  always_comb begin
    if (snp_wr)      ev = EV_SNP_WR;
    else if (snp_rd) ev = EV_SNP_RD;
    else if (evict)  ev = EV_EVICT;
    else if (cpu_wr) ev = EV_WR;
    else if (cpu_rd) ev = EV_RD;
    else             ev = EV_NONE;
  end
endmodule

// File: rtl/mesi_xition.sv
module mesi_xition
  import mesi_pkg::*;
(
  input  line_st_t  cur,
  input  line_ev_t  ev,
  input  logic      shared,
  output line_act_t act
);
  always_comb begin
    act = '{nxt: cur, cmd: CMD_NONE, wb: 1'b0, sup: 1'b0};
    unique case (ev)
      EV_RD: begin
        if (cur == ST_I) begin
          act.cmd = CMD_RDMISS;
          act.nxt = shared ? ST_S : ST_E;
        end
      end
      EV_WR: begin
        unique case (cur)
          ST_I: begin act.cmd = CMD_WRMISS; act.nxt = ST_M; end
          ST_S: begin act.cmd = CMD_INV;    act.nxt = ST_M; end
          ST_E: act.nxt = ST_M;
          ST_M: act.nxt = ST_M;
        endcase
      end
      EV_EVICT: begin
        act.wb  = (cur == ST_M);
        act.nxt = ST_I;
      end
      EV_SNP_RD: begin
        if (cur == ST_M) begin
          act.wb  = 1'b1;
          act.sup = 1'b1;
          act.nxt = ST_S;
        end else if (cur == ST_E) begin
          act.nxt = ST_S;
        end
      end
      EV_SNP_WR: begin
        act.wb  = (cur == ST_M);
        act.sup = (cur == ST_M);
        act.nxt = ST_I;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_rd_i,
  input  logic             cpu_wr_i,
  input  logic             evict_i,
  input  logic             snp_rd_i,
  input  logic             snp_wr_i,
  input  logic             shared_i,
  output logic [ST_W-1:0]  state_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             wb_o,
  output logic             supply_o
);
  line_ev_t  ev;
  line_act_t act;
  line_st_t  st_q;
  bus_cmd_t  cmd_q;

  mesi_evt_arb u_arb (
    .cpu_rd(cpu_rd_i), .cpu_wr(cpu_wr_i), .evict(evict_i),
    .snp_rd(snp_rd_i), .snp_wr(snp_wr_i), .ev(ev)
  );

  mesi_xition u_xit (
    .cur(st_q), .ev(ev), .shared(shared_i), .act(act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_I;
      cmd_q    <= CMD_NONE;
      wb_o     <= 1'b0;
      supply_o <= 1'b0;
    end else begin
      st_q     <= act.nxt;
      cmd_q    <= act.cmd;
      wb_o     <= act.wb;
      supply_o <= act.sup;
    end
  end

  assign state_o = st_q;
  assign cmd_o   = cmd_q;
endmodule

// File: rtl/mesi_line_chk.sv
module mesi_line_chk (
  input logic       clk,
  input logic       rst,
  input logic       cpu_rd_i,
  input logic       cpu_wr_i,
  input logic       evict_i,
  input logic       snp_rd_i,
  input logic       snp_wr_i,
  input logic [1:0] state_o,
  input logic [1:0] cmd_o,
  input logic       wb_o,
  input logic       supply_o
);
  logic cpu_only;
  assign cpu_only = !snp_rd_i && !snp_wr_i && !evict_i;

  assert_silent_upgrade_R5: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2 && cpu_wr_i && cpu_only) |=> (state_o == 2'd3 && cmd_o == 2'd0 && !wb_o));

  assert_shared_write_inv_R4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd1 && cpu_wr_i && cpu_only) |=> (state_o == 2'd3 && cmd_o == 2'd3));

  assert_snoop_write_kills_R8: assert property (@(posedge clk) disable iff (rst)
    snp_wr_i |=> (state_o == 2'd0));

  assert_wb_only_dirty_R9: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'd3) |=> !wb_o);

  assert_supply_has_wb_R7: assert property (@(posedge clk) disable iff (rst)
    supply_o |-> wb_o);

  assert_reads_keep_hit_R6: assert property (@(posedge clk) disable iff (rst)
    (state_o != 2'd0 && cpu_rd_i && !cpu_wr_i && cpu_only) |=> ($stable(state_o) && cmd_o == 2'd0));
endmodule

bind mesi_line_ctrl mesi_line_chk u_chk (
  .clk(clk), .rst(rst), .cpu_rd_i(cpu_rd_i), .cpu_wr_i(cpu_wr_i),
  .evict_i(evict_i), .snp_rd_i(snp_rd_i), .snp_wr_i(snp_wr_i),
  .state_o(state_o), .cmd_o(cmd_o), .wb_o(wb_o), .supply_o(supply_o)
);

// File: tb/sim_mesi_line_ctrl.sv
`timescale 1ns/1ps
module sim_mesi_line_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd = 0, wr = 0, ev = 0, srd = 0, swr = 0, sh = 0;
  logic [1:0] st, cmd;
  logic wb, sup;
  int total = 0, bad = 0;
  logic [1:0] m_st = 2'd0;
  logic [1:0] e_st, e_cmd;
  logic e_wb, e_sup;
  string e_tag;

  always #10 clk = ~clk;

  mesi_line_ctrl u0 (
    .clk(clk), .rst(rst), .cpu_rd_i(rd), .cpu_wr_i(wr), .evict_i(ev),
    .snp_rd_i(srd), .snp_wr_i(swr), .shared_i(sh),
    .state_o(st), .cmd_o(cmd), .wb_o(wb), .supply_o(sup)
  );

  task automatic model(input logic [1:0] s);
    e_st = s; e_cmd = 2'd0; e_wb = 0; e_sup = 0;
    if ((srd || swr) && (rd || wr || ev)) e_tag = "R10";
    else if (swr && srd) e_tag = "R10";
    else e_tag = "R11";
    if (swr) begin
      e_wb = (s == 3); e_sup = (s == 3); e_st = 0;
      if (e_tag == "R11") e_tag = "R8";
    end else if (srd) begin
      if (s == 3) begin e_wb = 1; e_sup = 1; e_st = 1; end
      else if (s == 2) e_st = 1;
      if (e_tag == "R11") e_tag = "R7";
    end else if (ev) begin
      e_wb = (s == 3); e_st = 0;
      e_tag = (wr || rd) ? "R10" : "R9";
    end else if (wr) begin
      case (s)
        2'd0: begin e_cmd = 2; e_st = 3; e_tag = "R3"; end
        2'd1: begin e_cmd = 3; e_st = 3; e_tag = "R4"; end
        2'd2: begin e_st = 3; e_tag = "R5"; end
        default: e_tag = "R6";
      endcase
      if (rd) e_tag = "R10";
    end else if (rd) begin
      if (s == 0) begin e_cmd = 1; e_st = sh ? 2'd1 : 2'd2; e_tag = "R2"; end
      else e_tag = "R6";
    end
  endtask

  task automatic check(input string tag, input logic [1:0] xs, input logic [1:0] xc,
                       input logic xw, input logic xp);
    total++;
    if (st !== xs || cmd !== xc || wb !== xw || sup !== xp) begin
      bad++;
      $display("FAIL %s: got st=%0d cmd=%0d wb=%0b sup=%0b exp st=%0d cmd=%0d wb=%0b sup=%0b",
               tag, st, cmd, wb, sup, xs, xc, xw, xp);
    end
  endtask

  // Apply one cycle of stimulus, then check the registered response.
  task automatic step(input logic r, input logic w, input logic e,
                      input logic sr, input logic sw, input logic s);
    rd = r; wr = w; ev = e; srd = sr; swr = sw; sh = s;
    model(m_st);
    @(negedge clk);
    check(e_tag, e_st, e_cmd, e_wb, e_sup);
    m_st = e_st;
    rd = 0; wr = 0; ev = 0; srd = 0; swr = 0; sh = 0;
  endtask

  initial begin
    #4000000;
    bad++; total++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", 0, 0, 0, 0);
    rst = 0;
    // directed walks
    step(1,0,0,0,0,0);  // R2 fill exclusive
    step(1,0,0,0,0,0);  // R6 hit
    step(0,1,0,0,0,0);  // R5 silent upgrade
    step(0,1,0,0,0,0);  // R6 write hit in M
    step(0,0,0,1,0,0);  // R7 M->S with wb
    step(0,1,0,0,0,0);  // R4 invalidate
    step(0,0,1,0,0,0);  // R9 evict M
    step(1,0,0,0,0,1);  // R2 fill shared
    step(0,0,1,0,0,0);  // R9 evict S silent
    step(0,1,0,0,0,0);  // R3 write miss
    step(0,0,0,1,1,0);  // R10 snp write beats read, R8
    step(1,0,0,0,0,0);  // R2
    step(0,1,0,1,0,0);  // R10 cpu write dropped, E->S
    step(0,1,1,0,0,0);  // R10 evict beats write
    step(0,0,0,0,0,0);  // R11 idle
    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] p;
      p = 8'($urandom);
      step(p[0], p[1] & p[2], p[3] & p[4] & p[5], p[6] & p[2] & p[4],
           p[7] & p[3] & p[1] & p[5], 1'($urandom));
    end
    rst = 1;
    @(negedge clk);
    check("R1", 0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule